// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through data cache and main memory. Every processor store updates the cache and must also reach memory. The block takes each store (address, data, byte enables) into a small queue so the processor can keep running while the slower memory finishes the write.

Stores go to memory one at a time, oldest first, over a request/acknowledge handshake. An entry leaves the queue only when memory acknowledges that its write completed. When every slot holds a pending write, the block stalls the processor's store port until a slot frees.

An optional comparator stalls a processor load whose word address matches any write still pending. The load then waits until that write has reached memory. The depth can be set as low as one entry.

Top module: `wt_store_buffer`

## Requirements
- R1: While `rst_n` is low and after it rises, the queue is empty, `mem_req` is low, and `st_stall` and `ld_stall` are low.
- R2: Stores are presented on `mem_addr`/`mem_data`/`mem_be` in the order they were accepted. Each store keeps the address, data and byte enables it was accepted with.
- R3: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high on the next cycle and the presented address, data and byte enables do not change.
- R4: An entry is removed only in a cycle where `mem_req` and `mem_ack` are both high. A `mem_ack` with `mem_req` low has no effect.
- R5: When all DEPTH slots are occupied and no retirement happens this cycle, `st_stall` is high. A store offered while `st_stall` is high is not accepted and never reaches memory.
- R6: If the queue is full and an entry retires in the same cycle, `st_stall` is low. A store offered in that cycle is accepted and later reaches memory.
- R7: With DEPTH = 1 the block keeps R1–R6, holding at most one pending write.
- R8: With LOAD_CHECK = 1, `ld_stall` is high exactly when `ld_valid` is high and `ld_addr` bits above the byte offset (bits [ADDR_W-1:2] for 32-bit data) equal those of any pending entry. With LOAD_CHECK = 0, `ld_stall` is always low.
- R9: A store accepted into an empty queue raises `mem_req` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Processor store request |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_stall | output | 1 | Store not accepted this cycle, buffer full |
| ld_valid | input | 1 | Processor load request |
| ld_addr | input | ADDR_W | Load byte address |
| ld_stall | output | 1 | Load matches a pending write |
| mem_req | output | 1 | Write request to memory |
| mem_addr | output | ADDR_W | Address of the oldest pending write |
| mem_data | output | DATA_W | Data of the oldest pending write |
| mem_be | output | DATA_W/8 | Byte enables of the oldest pending write |
| mem_ack | input | 1 | Memory reports the presented write complete |

## Verification
The bench goes after the full-queue retire cycle. A design that stalled there would lose throughput, and one that overwrote the head slot would drop or corrupt a write. It also sends acknowledges while the queue is empty: a design that counted them would underflow and later send garbage to memory.

The bench sends stores while the processor is stalled. If those stores leaked in, extra writes would appear on the memory port. Loads are aimed at addresses that differ only in their byte offset from a pending write, so a comparator that included those bits would let a stale load through. A single-entry copy checks the pointer wrap, where the write and read slots are the same slot.

// File: rtl/wtsb_pkg.sv
package wtsb_pkg;

  // Next slot index in a circular queue of the given depth.
  function automatic int unsigned slot_next(input int unsigned cur, input int unsigned depth);
    return (cur + 1 >= depth) ? 0 : cur + 1;
  endfunction

  // Word-granular form of a byte address: drop the byte offset bits.
  function automatic logic [63:0] word_of(input logic [63:0] byte_addr, input int unsigned off_bits);
    return byte_addr >> off_bits;
  endfunction

endpackage

// File: rtl/wtsb_queue.sv
module wtsb_queue #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [ADDR_W-1:0]       push_addr,
  input  logic [DATA_W-1:0]       push_data,
  input  logic [BE_W-1:0]         push_be,
  input  logic                    pop,
  output logic                    head_vld,
  output logic [ADDR_W-1:0]       head_addr,
  output logic [DATA_W-1:0]       head_data,
  output logic [BE_W-1:0]         head_be,
  output logic                    full,
  output logic [CNT_W-1:0]        count,
  output logic [DEPTH-1:0]        slot_vld,
  output logic [DEPTH*ADDR_W-1:0] slot_addr
);
  import wtsb_pkg::*;

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [BE_W-1:0]   be_q   [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      vld_q  <= '0;
    end else begin
      if (pop) begin
        vld_q[rd_ptr] <= 1'b0;
        rd_ptr <= PTR_W'(slot_next(32'(rd_ptr), DEPTH));
      end
      if (push) begin
        vld_q[wr_ptr] <= 1'b1;
        wr_ptr <= PTR_W'(slot_next(32'(wr_ptr), DEPTH));
      end
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
      be_q[wr_ptr]   <= push_be;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_flat
      assign slot_addr[gi*ADDR_W +: ADDR_W] = addr_q[gi];
    end
  endgenerate

  assign slot_vld  = vld_q;
  assign count     = cnt_q;
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign head_vld  = (cnt_q != '0);
  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];
  assign head_be   = be_q[rd_ptr];

  // No slot is written while full unless the head leaves in the same cycle.
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push) |-> pop);

  // Nothing is removed from an empty queue.
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !head_vld |-> !pop);

  // The valid vector tracks the occupancy count.
  assert_count_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == 32'(cnt_q));

endmodule

// File: rtl/wtsb_ld_match.sv
module wtsb_ld_match #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 4,
  parameter bit LOAD_CHECK = 1'b1,
  localparam int OFF_W     = $clog2(DATA_W / 8)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_valid,
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic [DEPTH-1:0]        slot_vld,
  input  logic [DEPTH*ADDR_W-1:0] slot_addr,
  output logic                    ld_stall
);
  import wtsb_pkg::*;

  logic [DEPTH-1:0] hit_vec;
  logic             any_hit;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
      assign hit_vec[gi] = slot_vld[gi] &&
        (word_of(64'(slot_addr[gi*ADDR_W +: ADDR_W]), OFF_W) == word_of(64'(ld_addr), OFF_W));
    end
  endgenerate

  assign any_hit  = |hit_vec;
  assign ld_stall = LOAD_CHECK && ld_valid && any_hit;

  // A load stall never appears without a load request.
  assert_ld_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !ld_stall);

  // A stall implies at least one pending slot.
  assert_ld_needs_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> (slot_vld != '0));

endmodule

// File: rtl/wt_store_buffer.sv
module wt_store_buffer #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 4,
  parameter bit LOAD_CHECK = 1'b1,
  localparam int BE_W      = DATA_W / 8,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  output logic              st_stall,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_stall,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be,
  input  logic              mem_ack
);

  logic                    accept_ev;
  logic                    retire_ev;
  logic                    full;
  logic [CNT_W-1:0]        count;
  logic [DEPTH-1:0]        slot_vld;
  logic [DEPTH*ADDR_W-1:0] slot_addr;

  assign retire_ev = mem_req && mem_ack;
  assign st_stall  = full && !retire_ev;
  assign accept_ev = st_valid && !st_stall;

  wtsb_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept_ev),
    .push_addr (st_addr),
    .push_data (st_data),
    .push_be   (st_be),
    .pop       (retire_ev),
    .head_vld  (mem_req),
    .head_addr (mem_addr),
    .head_data (mem_data),
    .head_be   (mem_be),
    .full      (full),
    .count     (count),
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr)
  );

  wtsb_ld_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .LOAD_CHECK(LOAD_CHECK)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_addr   (ld_addr),
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .ld_stall  (ld_stall)
  );

  // First cycle out of reset: nothing is requested.
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!mem_req && !st_stall));

  // An unacknowledged request holds its fields.
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

  // Occupancy never drops without a completed handshake.
  assert_retire_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_ev |=> (count >= $past(count)));

  // A retiring cycle never stalls the store port.
  assert_no_false_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retire_ev |-> !st_stall);

  // A store into an empty queue is requested on the next cycle.
  assert_empty_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && st_valid) |=> mem_req);

endmodule

// File: tb/sim_wt_store_buffer.sv
`timescale 1ns/1ps
module sim_wt_store_buffer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_be = '0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_addr = '0;
  logic        mem_ack = 1'b0;

  logic        st_stall0, ld_stall0, mem_req0;
  logic [31:0] mem_addr0, mem_data0;
  logic [3:0]  mem_be0;
  logic        st_stall1, ld_stall1, mem_req1;
  logic [31:0] mem_addr1, mem_data1;
  logic [3:0]  mem_be1;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  wt_store_buffer #(.ADDR_W(32), .DATA_W(32), .DEPTH(4), .LOAD_CHECK(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_be(st_be), .st_stall(st_stall0), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_stall(ld_stall0), .mem_req(mem_req0), .mem_addr(mem_addr0), .mem_data(mem_data0),
    .mem_be(mem_be0), .mem_ack(mem_ack));

  wt_store_buffer #(.ADDR_W(32), .DATA_W(32), .DEPTH(1), .LOAD_CHECK(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_be(st_be), .st_stall(st_stall1), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_stall(ld_stall1), .mem_req(mem_req1), .mem_addr(mem_addr1), .mem_data(mem_data1),
    .mem_be(mem_be1), .mem_ack(mem_ack));

  // Reference queues: {addr, data, be}
  logic [67:0] q0[$];
  logic [67:0] q1[$];
  bit held0 = 1'b0, held1 = 1'b0;
  bit filled0 = 1'b0, filled1 = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ld_hit(input logic [67:0] q[$], input logic [31:0] a);
    foreach (q[i]) if (q[i][67:38] == a[31:2]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic cyc(input bit sv, input logic [31:0] sa, input logic [31:0] sd, input logic [3:0] sb,
                     input bit lv, input logic [31:0] la, input bit ak);
    bit req0, req1, stl0, stl1, ret0, ret1;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
    ld_valid = lv; ld_addr = la; mem_ack = ak;
    #1;
    // deep instance
    req0 = (q0.size() > 0);
    ret0 = req0 && ak;
    stl0 = (q0.size() == 4) && !ret0;
    chk(mem_req0 == req0, filled0 ? "R9 mem_req u0" : "R4 mem_req u0", 68'(mem_req0), 68'(req0));
    if (req0)
      chk({mem_addr0, mem_data0, mem_be0} == q0[0], held0 ? "R3 held fields u0" : "R2 order u0",
          {mem_addr0, mem_data0, mem_be0}, q0[0]);
    chk(st_stall0 == stl0, (q0.size() == 4 && ret0) ? "R6 full+retire u0" : "R5 stall u0",
        68'(st_stall0), 68'(stl0));
    chk(ld_stall0 == (lv && ld_hit(q0, la)), "R8 load match u0", 68'(ld_stall0), 68'(lv && ld_hit(q0, la)));
    // single-entry instance
    req1 = (q1.size() > 0);
    ret1 = req1 && ak;
    stl1 = (q1.size() == 1) && !ret1;
    chk(mem_req1 == req1, "R7 mem_req u1", 68'(mem_req1), 68'(req1));
    if (req1)
      chk({mem_addr1, mem_data1, mem_be1} == q1[0], "R7 fields u1", {mem_addr1, mem_data1, mem_be1}, q1[0]);
    chk(st_stall1 == stl1, "R7 stall u1", 68'(st_stall1), 68'(stl1));
    chk(ld_stall1 == 1'b0, "R8 check disabled u1", 68'(ld_stall1), 68'(0));
    @(posedge clk);
    held0 = req0 && !ak;
    held1 = req1 && !ak;
    filled0 = (q0.size() == 0) && sv;
    filled1 = (q1.size() == 0) && sv;
    if (ret0) void'(q0.pop_front());
    if (sv && !stl0) q0.push_back({sa, sd, sb});
    if (ret1) void'(q1.pop_front());
    if (sv && !stl1) q1.push_back({sa, sd, sb});
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk(!mem_req0 && !st_stall0 && !ld_stall0, "R1 reset u0", 68'({mem_req0, st_stall0, ld_stall0}), 68'(0));
    chk(!mem_req1 && !st_stall1, "R1 reset u1", 68'({mem_req1, st_stall1}), 68'(0));
    rst_n = 1'b1;
    // R4: acknowledge on an empty queue is ignored
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 32'h10, 1);
    // R5: fill with memory silent, then offer extra stores
    for (int i = 0; i < 6; i++)
      cyc(1, 32'h100 + 32'(i * 4), 32'hA000 + 32'(i), 4'(i + 1), 0, 0, 0);
    // R8: load word matches with different byte offsets
    cyc(0, 0, 0, 0, 1, 32'h103, 0);
    cyc(0, 0, 0, 0, 1, 32'h10A, 0);
    cyc(0, 0, 0, 0, 1, 32'h110, 0);
    // R6: full and retiring while a new store arrives
    cyc(1, 32'h200, 32'hBEEF, 4'hF, 1, 32'h100, 1);
    cyc(1, 32'h204, 32'hCAFE, 4'h3, 0, 0, 1);
    // R3: hold a request for several cycles
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    // drain
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 1, 32'h200, 1);
    // mixed random traffic
    for (int i = 0; i < 600; i++)
      cyc(1'($urandom_range(0, 1)), 32'($urandom_range(0, 31)), $urandom, 4'($urandom),
          1'($urandom_range(0, 1)), 32'($urandom_range(0, 31)), 1'($urandom_range(0, 2) == 0));
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule